// File: doc/BRIEF.md
# Transaction Packet Classifier and Tap

This block sits beside a 64-bit packet stream that carries transaction-layer packets of a serial expansion bus. The stream has data, valid, start-of-packet and end-of-packet signals. The block watches it and never drives it. On the first valid beat of each packet it decodes the fixed-format leading header double word (DW). From that word it works out the packet class, whether the header is three or four DWs long, how many payload DWs follow, and whether a trailing digest DW is present.

Packets of three classes are copied to a log stream one clock cycle after the input beat: memory read requests, memory write requests and completions carrying data. Each DW lane of the log beat is marked as header, as payload or as unused. The digest DW and any padding lane are never marked. Packets of any other class produce no log traffic. A free-running counter per class records how many packets of that class have started.

Top module: `tlp_tap`

## Requirements
- R1: The leading DW gives the format in bits [30:29] and the type in bits [28:24]. Type 00000 with format bit 30 clear is a memory read (log class 00). Type 00000 with format bit 30 set is a memory write (class 01). Type 01010 with format 10 is a completion with data (class 10). Every other combination is class "other" (11) and is not logged.
- R2: The four packet counters are zero after reset. Each counter rises by exactly one, visible on the cycle after the start-of-packet beat of a packet of its class, and no other counter changes on that beat.
- R3: For every valid beat of a logged packet, `log_valid` is high exactly one clock later. `log_data` then equals that beat's data, and `log_sop` and `log_eop` copy its flags. `log_cls` gives the class.
- R4: Beats of packets of class "other", and beats with `s_valid` low, leave `log_valid`, `log_keep` and `log_hdr` low in the following cycle.
- R5: DW number k of a packet travels in beat k/2. Even k sits in bits [31:0] and odd k sits in bits [63:32]. DWs with k below the header size (3 when format bit 29 is clear, 4 when it is set) have both their `log_keep` and `log_hdr` bits high.
- R6: When format bit 30 is set, the payload length comes from bits [9:0], where 0 means 1024. Payload DWs have `log_keep` high and `log_hdr` low. When format bit 30 is clear there is no payload, and only header lanes are kept.
- R7: When bit 15 of the leading DW is set, the DW after the payload is a digest. Its lane, and any unused lane of the last beat, has `log_keep` and `log_hdr` low.
- R8: After an end-of-packet beat, valid beats without start-of-packet are ignored until the next start-of-packet. A start-of-packet flag on a beat with `s_valid` low does not open a packet.
- R9: After reset, all log outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Observed stream data, two DWs per beat |
| s_valid | input | 1 | Observed beat valid |
| s_sop | input | 1 | Observed first beat of packet |
| s_eop | input | 1 | Observed last beat of packet |
| log_data | output | 64 | Logged beat data |
| log_valid | output | 1 | Logged beat valid |
| log_sop | output | 1 | Logged beat is first of packet |
| log_eop | output | 1 | Logged beat is last of packet |
| log_keep | output | 2 | Per-lane DW holds header or payload |
| log_hdr | output | 2 | Per-lane DW is a header DW |
| log_cls | output | 2 | Class of the logged packet |
| cnt_mrd | output | CNT_W | Memory read packets seen |
| cnt_mwr | output | CNT_W | Memory write packets seen |
| cnt_cpl | output | CNT_W | Completions with data seen |
| cnt_oth | output | CNT_W | Other packets seen |

## Verification
Reads with three- and four-DW headers show whether the header size is taken from the format bit, with no payload lanes kept. Writes with odd and even payload lengths, under both header sizes, move the payload start between lanes and expose off-by-one errors at the header/payload and payload/end borders. Completions with a digest, and one write with the zero-means-1024 length, test the payload end. Other classes, idle beats inside packets, stray beats after an end-of-packet, and a randomly sized mix check that only selected packet beats reach the log and that every counter tracks its own class.

// File: rtl/tlp_tap.sv
module tlp_tap #(
  parameter int CNT_W = 16,
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      s_data,
  input  logic             s_valid,
  input  logic             s_sop,
  input  logic             s_eop,
  output logic [63:0]      log_data,
  output logic             log_valid,
  output logic             log_sop,
  output logic             log_eop,
  output logic [1:0]       log_keep,
  output logic [1:0]       log_hdr,
  output logic [1:0]       log_cls,
  output logic [CNT_W-1:0] cnt_mrd,
  output logic [CNT_W-1:0] cnt_mwr,
  output logic [CNT_W-1:0] cnt_cpl,
  output logic [CNT_W-1:0] cnt_oth
);
  localparam int LANES = 2;
  localparam logic [4:0] TY_MEM = 5'b00000;
  localparam logic [4:0] TY_CPL = 5'b01010;
  localparam logic [1:0] C_MRD = 2'd0, C_MWR = 2'd1, C_CPL = 2'd2, C_OTH = 2'd3;

  logic [1:0] fmt_w;
  logic [4:0] typ_w;
  logic [1:0] cls_w;
  logic [POS_W-1:0] hlen_w, plen_w;

  assign fmt_w  = s_data[30:29];
  assign typ_w  = s_data[28:24];
  assign hlen_w = fmt_w[0] ? POS_W'(4) : POS_W'(3);
  assign plen_w = !fmt_w[1] ? '0 :
                  (s_data[9:0] == 10'd0) ? POS_W'(1024) : POS_W'(s_data[9:0]);

  always_comb begin
    if (typ_w == TY_MEM)                         cls_w = fmt_w[1] ? C_MWR : C_MRD;
    else if (typ_w == TY_CPL && fmt_w == 2'b10)  cls_w = C_CPL;
    else                                         cls_w = C_OTH;
  end

  logic             in_pkt_q;
  logic [1:0]       cls_q;
  logic [POS_W-1:0] hlen_q, end_q, pos_q;

  logic             first, active, sel;
  logic [1:0]       cur_cls;
  logic [POS_W-1:0] cur_h, cur_end, cur_pos;
  logic [LANES-1:0] keep_w, hdr_w;

  assign first   = s_valid & s_sop;
  assign active  = s_valid & (s_sop | in_pkt_q);
  assign cur_cls = first ? cls_w : cls_q;
  assign cur_h   = first ? hlen_w : hlen_q;
  assign cur_end = first ? hlen_w + plen_w : end_q;
  assign cur_pos = first ? '0 : pos_q;
  assign sel     = active & (cur_cls != C_OTH);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [POS_W-1:0] idx;
    assign idx       = cur_pos + POS_W'(i);
    assign keep_w[i] = sel & (idx < cur_end);
    assign hdr_w[i]  = sel & (idx < cur_h);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      cls_q    <= C_OTH;
      hlen_q   <= '0;
      end_q    <= '0;
      pos_q    <= '0;
    end else if (active) begin
      in_pkt_q <= !s_eop;
      pos_q    <= cur_pos + POS_W'(LANES);
      if (first) begin
        cls_q  <= cls_w;
        hlen_q <= hlen_w;
        end_q  <= hlen_w + plen_w;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log_data  <= '0;
      log_valid <= 1'b0;
      log_sop   <= 1'b0;
      log_eop   <= 1'b0;
      log_keep  <= '0;
      log_hdr   <= '0;
      log_cls   <= '0;
    end else begin
      log_valid <= sel;
      log_sop   <= sel & s_sop;
      log_eop   <= sel & s_eop;
      log_keep  <= keep_w;
      log_hdr   <= hdr_w;
      if (sel) begin
        log_data <= s_data;
        log_cls  <= cur_cls;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_mrd <= '0;
      cnt_mwr <= '0;
      cnt_cpl <= '0;
      cnt_oth <= '0;
    end else if (first) begin
      case (cls_w)
        C_MRD:   cnt_mrd <= cnt_mrd + 1'b1;
        C_MWR:   cnt_mwr <= cnt_mwr + 1'b1;
        C_CPL:   cnt_cpl <= cnt_cpl + 1'b1;
        default: cnt_oth <= cnt_oth + 1'b1;
      endcase
    end
  end
endmodule

module tlp_tap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      s_data,
  input logic             s_valid,
  input logic             s_sop,
  input logic [63:0]      log_data,
  input logic             log_valid,
  input logic             log_sop,
  input logic [1:0]       log_keep,
  input logic [1:0]       log_hdr,
  input logic [1:0]       log_cls,
  input logic [CNT_W-1:0] cnt_mrd,
  input logic [CNT_W-1:0] cnt_mwr,
  input logic [CNT_W-1:0] cnt_cpl,
  input logic [CNT_W-1:0] cnt_oth
);
  // R3: a log beat always follows a valid input beat carrying the same data
  a_r3_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> ($past(s_valid) && log_data == $past(s_data)));

  // R4: lane marks only appear on log beats of selected classes
  a_r4_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (log_keep != 2'b00) |-> (log_valid && log_cls != 2'b11));

  // R5: the first beat of a logged packet carries two header DWs
  a_r5_sop_all_header: assert property (@(posedge clk) disable iff (!rst_n)
    log_sop |-> (log_keep == 2'b11 && log_hdr == 2'b11 && $past(s_sop)));

  // R6: a header lane is always a kept lane
  a_r6_hdr_in_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (log_hdr & ~log_keep) == 2'b00);

  // R2: at most one counter moves per cycle, and only after a start beat
  a_r2_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cnt_mrd != $past(cnt_mrd), cnt_mwr != $past(cnt_mwr),
                cnt_cpl != $past(cnt_cpl), cnt_oth != $past(cnt_oth)}) <= 1);

  a_r2_count_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mrd != $past(cnt_mrd) || cnt_mwr != $past(cnt_mwr) ||
     cnt_cpl != $past(cnt_cpl) || cnt_oth != $past(cnt_oth))
    |-> ($past(s_valid) && $past(s_sop)));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mrd != $past(cnt_mrd)) |-> (cnt_mrd == $past(cnt_mrd) + 1'b1));
endmodule

bind tlp_tap tlp_tap_chk #(.CNT_W(CNT_W)) u_tlp_tap_chk (
  .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_sop(s_sop),
  .log_data(log_data), .log_valid(log_valid), .log_sop(log_sop),
  .log_keep(log_keep), .log_hdr(log_hdr), .log_cls(log_cls),
  .cnt_mrd(cnt_mrd), .cnt_mwr(cnt_mwr), .cnt_cpl(cnt_cpl), .cnt_oth(cnt_oth)
);

// File: tb/tlp_tap_bench.sv
module tlp_tap_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] s_data = '0;
  logic s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic [63:0] log_data;
  logic log_valid, log_sop, log_eop;
  logic [1:0] log_keep, log_hdr, log_cls;
  logic [CNT_W-1:0] cnt_mrd, cnt_mwr, cnt_cpl, cnt_oth;

  int n_vec = 0, n_bad = 0, pkt_id = 0;
  int e_mrd = 0, e_mwr = 0, e_cpl = 0, e_oth = 0;

  always #2.5 clk = ~clk;

  tlp_tap #(.CNT_W(CNT_W)) u_tlp_tap (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_sop(s_sop),
    .s_eop(s_eop), .log_data(log_data), .log_valid(log_valid), .log_sop(log_sop),
    .log_eop(log_eop), .log_keep(log_keep), .log_hdr(log_hdr), .log_cls(log_cls),
    .cnt_mrd(cnt_mrd), .cnt_mwr(cnt_mwr), .cnt_cpl(cnt_cpl), .cnt_oth(cnt_oth)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_counts();
    chk("R2 read count",  64'(cnt_mrd), 64'(e_mrd));
    chk("R2 write count", 64'(cnt_mwr), 64'(e_mwr));
    chk("R2 cpl count",   64'(cnt_cpl), 64'(e_cpl));
    chk("R2 other count", 64'(cnt_oth), 64'(e_oth));
  endtask

  task automatic chk_idle(input string req);
    chk(req, {59'd0, log_valid, log_keep, log_hdr}, 64'd0);
  endtask

  task automatic send_pkt(input logic [1:0] fmt, input logic [4:0] typ, input logic td,
                          input logic [9:0] len, input bit gaps);
    int h, p, tot, nb;
    logic [1:0] cls;
    logic [31:0] d0, d1;
    h   = fmt[0] ? 4 : 3;
    p   = fmt[1] ? ((len == 10'd0) ? 1024 : int'(len)) : 0;
    tot = h + p + (td ? 1 : 0);
    nb  = (tot + 1) / 2;
    if (typ == 5'b00000)                     cls = fmt[1] ? 2'b01 : 2'b00;
    else if (typ == 5'b01010 && fmt == 2'b10) cls = 2'b10;
    else                                     cls = 2'b11;
    pkt_id++;
    for (int b = 0; b < nb; b++) begin
      logic [1:0] ek, eh;
      d0 = (b == 0) ? {1'b0, fmt, typ, 8'h00, td, 5'd0, len}
                    : {8'(pkt_id), 8'h5A, 16'(2*b)};
      d1 = {8'(pkt_id), 8'hA5, 16'(2*b+1)};
      for (int i = 0; i < 2; i++) begin
        ek[i] = (cls != 2'b11) && (2*b+i < h+p);
        eh[i] = (cls != 2'b11) && (2*b+i < h);
      end
      @(negedge clk);
      s_data = {d1, d0}; s_valid = 1'b1; s_sop = (b == 0); s_eop = (b == nb-1);
      @(posedge clk); #1;
      if (cls != 2'b11) begin
        chk("R3/R1 beat flags and class", {56'd0, log_valid, log_sop, log_eop, log_cls, 3'd0},
            {56'd0, 1'b1, b == 0, b == nb-1, cls, 3'd0});
        chk("R3 beat data", log_data, {d1, d0});
        chk("R5/R6/R7 lane marks", {60'd0, log_keep, log_hdr}, {60'd0, ek, eh});
      end else begin
        chk_idle("R4 other class not logged");
      end
      if (gaps && b != nb-1) begin
        @(negedge clk);
        s_valid = 1'b0; s_sop = 1'b1; s_eop = 1'b1; s_data = ~s_data;
        @(posedge clk); #1;
        chk_idle("R4/R8 idle beat not logged");
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    case (cls)
      2'b00: e_mrd++;
      2'b01: e_mwr++;
      2'b10: e_cpl++;
      default: e_oth++;
    endcase
    @(posedge clk); #1;
    chk_counts();
  endtask

  task automatic t_reset();
    chk("R9 log outputs after reset", {log_data, 59'd0, log_valid, log_sop, log_eop, log_keep, log_hdr, log_cls}[122:0] == 0 ? 64'd0 : 64'd1, 64'd0);
    chk_counts();
  endtask

  task automatic t_reads();
    send_pkt(2'b00, 5'b00000, 1'b0, 10'd1, 1'b0);
    send_pkt(2'b01, 5'b00000, 1'b0, 10'd8, 1'b0);
    send_pkt(2'b00, 5'b00000, 1'b1, 10'd2, 1'b0);
  endtask

  task automatic t_writes();
    send_pkt(2'b10, 5'b00000, 1'b0, 10'd1, 1'b0);
    send_pkt(2'b10, 5'b00000, 1'b0, 10'd4, 1'b0);
    send_pkt(2'b11, 5'b00000, 1'b0, 10'd5, 1'b0);
    send_pkt(2'b11, 5'b00000, 1'b0, 10'd2, 1'b0);
    send_pkt(2'b10, 5'b00000, 1'b0, 10'd0, 1'b0);
  endtask

  task automatic t_cpl_digest();
    send_pkt(2'b10, 5'b01010, 1'b1, 10'd1, 1'b0);
    send_pkt(2'b10, 5'b01010, 1'b1, 10'd2, 1'b0);
    send_pkt(2'b10, 5'b01010, 1'b0, 10'd3, 1'b0);
    send_pkt(2'b11, 5'b00000, 1'b1, 10'd4, 1'b0);
  endtask

  task automatic t_others();
    send_pkt(2'b00, 5'b01010, 1'b0, 10'd0, 1'b0);
    send_pkt(2'b00, 5'b00100, 1'b0, 10'd1, 1'b0);
    send_pkt(2'b11, 5'b10010, 1'b0, 10'd3, 1'b0);
    send_pkt(2'b10, 5'b00010, 1'b0, 10'd1, 1'b0);
  endtask

  task automatic t_gaps_and_strays();
    send_pkt(2'b10, 5'b00000, 1'b1, 10'd6, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      s_data = {32'h0000_0001, 32'h4000_0004}; s_valid = 1'b1; s_sop = 1'b0; s_eop = (k == 2);
      @(posedge clk); #1;
      chk_idle("R8 stray beat after end");
    end
    @(negedge clk);
    s_valid = 1'b0; s_eop = 1'b0;
    @(posedge clk); #1;
    chk_counts();
    send_pkt(2'b01, 5'b00000, 1'b0, 10'd0, 1'b1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [1:0] f;
      logic [4:0] t;
      f = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0, 1:    t = 5'b00000;
        2:       t = 5'b01010;
        default: t = 5'b00100;
      endcase
      send_pkt(f, t, 1'($urandom_range(0, 1)), 10'($urandom_range(1, 40)),
               $urandom_range(0, 3) == 0);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_reads();
    t_writes();
    t_cpl_digest();
    t_others();
    t_gaps_and_strays();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule